// File: doc/BRIEF.md
# Dynamic Frequency Profile Selector

This block holds four stored feedback-divider words for a PLL and keeps one of them as the active divider. A 2-bit profile selection picks which stored word is the target. When the target changes, the block does not jump to it. It walks the active divider toward the target by one unit on each step tick, and it raises an overshoot-reduction enable while the walk is under way.

The selection can come from three places. The first is the output-enable pin together with the serial-clock pin. The second is the serial-data and serial-clock pins, used as plain level inputs. The third is a 2-bit register field. Which one applies depends on a frequency-control enable bit, a 2-bit pin-function select, and the level of the serial-clock pin captured while reset is held.

Pin levels pass through two synchronizing flops. A new selection becomes the target only after two consecutive step ticks have seen the same value. A selection that arrives while the divider is still moving replaces the target, and the walk continues from wherever the divider is at that moment.

Top module: `freq_profile_stepper`

## Requirements
- R1: While reset is held and just after it is released, the active divider equals stored word 0, and busy and overshoot-enable are low.
- R2: With the enable bit at 0, changes on every selection input are ignored: the target profile does not change, and a divider at rest stays where it is.
- R3: With enable at 1 and pin-function select equal to 2'b11, the selection is {serial-clock pin, output-enable pin}. Bit 1 is the clock pin and bit 0 is the enable pin. The register field is ignored.
- R4: With enable at 1, pin-function select not 2'b11, and the serial-clock pin low while reset was held, the selection is {serial-clock pin, serial-data pin}. Bit 1 is the clock pin and bit 0 is the data pin. The register field is ignored.
- R5: With enable at 1, pin-function select not 2'b11, and the serial-clock pin high while reset was held, the selection is the 2-bit register field.
- R6: On each step tick while the active divider differs from the target, the divider moves by exactly one toward the target. It lands exactly on the target and then holds.
- R7: Without a step tick the active divider does not change.
- R8: Busy and overshoot-enable are high exactly while the active divider differs from the target, and low once they are equal.
- R9: A selection committed during a walk replaces the target, and the walk continues from the current divider value.
- R10: A selection becomes the target only on the second of two consecutive step ticks that both sample it. A value present at a single tick is never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the serial-clock pin level is captured while it is held |
| prof_words_i | input | 4*DIV_W | Four stored divider words; word k sits at bits [k*DIV_W +: DIV_W] |
| ctl_en_i | input | 1 | Frequency-control enable |
| pin_fn_i | input | 2 | Pin-function select; 2'b11 selects the single-pin scheme |
| reg_sel_i | input | 2 | Register-field selection |
| oe_pin_i | input | 1 | Output-enable pin level |
| scl_pin_i | input | 1 | Serial-clock pin level |
| sda_pin_i | input | 1 | Serial-data pin level |
| step_tick_i | input | 1 | One-cycle pulse that allows one divider step |
| div_o | output | DIV_W | Active divider word |
| busy_o | output | 1 | Divider walk in progress |
| ovr_en_o | output | 1 | Overshoot-reduction enable |

## Verification
A wrong source-select decision or a stale power-on level shows up as the divider walking toward the wrong stored word. This is visible on `div_o` within one tick after the two-tick commit. A faulty qualifier shows up as a commit one tick early or late, or as a one-tick glitch that moves the divider. A stepping error shows up on the first tick as a change other than ±1, or as the divider overshooting the target and then coming back. Every tick in every scenario is compared against a value worked out from the stored words alone.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int NUM_PROF = 4;
    localparam int SEL_W    = $clog2(NUM_PROF);
    localparam logic [1:0] FN_SINGLE_PIN = 2'b11;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_OE_SCL = 2'd1,
        SRC_PINS   = 2'd2,
        SRC_REG    = 2'd3
    } sel_src_e;

    function automatic sel_src_e pick_src(input logic en,
                                          input logic [1:0] fn,
                                          input logic por_scl);
        if (!en)                      return SRC_OFF;
        else if (fn == FN_SINGLE_PIN) return SRC_OE_SCL;
        else if (!por_scl)            return SRC_PINS;
        else                          return SRC_REG;
    endfunction

endpackage

// File: rtl/fps_pin_sync.sv
module fps_pin_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/fps_sel_source.sv
module fps_sel_source
    import fps_pkg::*;
(
    input  logic       en_i,
    input  logic [1:0] fn_i,
    input  logic       por_scl_i,
    input  logic       oe_s_i,
    input  logic       scl_s_i,
    input  logic       sda_s_i,
    input  sel_t       reg_sel_i,
    output sel_src_e   src_o,
    output sel_t       raw_sel_o
);
    always_comb begin
        src_o = pick_src(en_i, fn_i, por_scl_i);
        unique case (src_o)
            SRC_OE_SCL: raw_sel_o = {scl_s_i, oe_s_i};
            SRC_PINS:   raw_sel_o = {scl_s_i, sda_s_i};
            SRC_REG:    raw_sel_o = reg_sel_i;
            default:    raw_sel_o = '0;
        endcase
    end
endmodule

// File: rtl/fps_sel_qualify.sv
module fps_sel_qualify
    import fps_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic tick_i,
    input  sel_t raw_sel_i,
    output sel_t sel_o
);
    sel_t smp_q, sel_q;
    logic smp_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q     <= '0;
            smp_vld_q <= 1'b0;
            sel_q     <= '0;
        end else if (!active_i) begin
            smp_vld_q <= 1'b0;
        end else if (tick_i) begin
            smp_q     <= raw_sel_i;
            smp_vld_q <= 1'b1;
            if (smp_vld_q && (raw_sel_i == smp_q))
                sel_q <= raw_sel_i;
        end
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/fps_ramp.sv
module fps_ramp
    import fps_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PROF*DIV_W-1:0]   words_i,
    input  sel_t                        sel_i,
    input  logic                        tick_i,
    output logic [DIV_W-1:0]            div_o,
    output logic                        busy_o
);
    logic [DIV_W-1:0] cur_q, tgt;

    assign tgt = words_i[sel_i*DIV_W +: DIV_W];

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= words_i[DIV_W-1:0];
        else if (tick_i && (cur_q != tgt))
            cur_q <= (cur_q < tgt) ? cur_q + DIV_W'(1) : cur_q - DIV_W'(1);
    end

    assign div_o  = cur_q;
    assign busy_o = (cur_q != tgt);
endmodule

// File: rtl/freq_profile_stepper.sv
module freq_profile_stepper
    import fps_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_PROF*DIV_W-1:0] prof_words_i,
    input  logic                      ctl_en_i,
    input  logic [1:0]                pin_fn_i,
    input  logic [1:0]                reg_sel_i,
    input  logic                      oe_pin_i,
    input  logic                      scl_pin_i,
    input  logic                      sda_pin_i,
    input  logic                      step_tick_i,
    output logic [DIV_W-1:0]          div_o,
    output logic                      busy_o,
    output logic                      ovr_en_o
);
    logic     por_scl_q;
    logic [2:0] pins_s;
    sel_src_e src;
    sel_t     raw_sel, sel_q;
    logic     busy;

    always_ff @(posedge clk) begin
        if (rst) por_scl_q <= scl_pin_i;
    end

    fps_pin_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_pin_i, sda_pin_i, oe_pin_i}),
        .q_o (pins_s)
    );

    fps_sel_source u_src (
        .en_i      (ctl_en_i),
        .fn_i      (pin_fn_i),
        .por_scl_i (por_scl_q),
        .oe_s_i    (pins_s[0]),
        .scl_s_i   (pins_s[2]),
        .sda_s_i   (pins_s[1]),
        .reg_sel_i (reg_sel_i),
        .src_o     (src),
        .raw_sel_o (raw_sel)
    );

    fps_sel_qualify u_qual (
        .clk       (clk),
        .rst       (rst),
        .active_i  (src != SRC_OFF),
        .tick_i    (step_tick_i),
        .raw_sel_i (raw_sel),
        .sel_o     (sel_q)
    );

    fps_ramp #(.DIV_W(DIV_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .words_i (prof_words_i),
        .sel_i   (sel_q),
        .tick_i  (step_tick_i),
        .div_o   (div_o),
        .busy_o  (busy)
    );

    assign busy_o   = busy;
    assign ovr_en_o = busy;
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_en_i,
    input logic             step_tick_i,
    input logic [DIV_W-1:0] div_o,
    input logic             busy_o,
    input logic [1:0]       sel_q
);
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        step_tick_i |=> (div_o == $past(div_o)) ||
                        (div_o == $past(div_o) + DIV_W'(1)) ||
                        (div_o == $past(div_o) - DIV_W'(1))); // R6

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_tick_i |=> $stable(div_o)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> (div_o == $past(div_o))); // R8

    AST_OFF_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
        !ctl_en_i |=> $stable(sel_q)); // R2

    AST_COMMIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (sel_q != $past(sel_q)) |-> $past(step_tick_i)); // R10
endmodule

bind freq_profile_stepper fps_checker #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_en_i    (ctl_en_i),
    .step_tick_i (step_tick_i),
    .div_o       (div_o),
    .busy_o      (busy_o),
    .sel_q       (sel_q)
);

// File: tb/freq_profile_stepper_bench.sv
module freq_profile_stepper_bench;
    localparam int DIV_W = 16;
    localparam logic [DIV_W-1:0] W0 = 16'd100, W1 = 16'd106, W2 = 16'd95, W3 = 16'd103;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4*DIV_W-1:0] words;
    logic ctl_en = 1'b0, oe = 1'b0, scl = 1'b1, sda = 1'b0, tick = 1'b0;
    logic [1:0] pin_fn = 2'b00, reg_sel = 2'b00;
    logic [DIV_W-1:0] div;
    logic busy, ovr;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    assign words = {W3, W2, W1, W0};

    freq_profile_stepper #(.DIV_W(DIV_W)) u_freq_profile_stepper (
        .clk(clk), .rst(rst), .prof_words_i(words), .ctl_en_i(ctl_en),
        .pin_fn_i(pin_fn), .reg_sel_i(reg_sel), .oe_pin_i(oe),
        .scl_pin_i(scl), .sda_pin_i(sda), .step_tick_i(tick),
        .div_o(div), .busy_o(busy), .ovr_en_o(ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input int exp_div, input bit exp_busy);
        chk(div == DIV_W'(exp_div), req, int'(div), exp_div);
        chk(busy == exp_busy, {req, " busy"}, int'(busy), int'(exp_busy));
        chk(ovr == exp_busy, {req, " ovr"}, int'(ovr), int'(exp_busy));
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic settle_commit();
        repeat (4) @(negedge clk);
        do_tick();
        do_tick();
    endtask

    task automatic walk(input string req, input int from, input int to);
        int v = from;
        while (v != to) begin
            chk_state(req, v, 1'b1);
            do_tick();
            v = (v < to) ? v + 1 : v - 1;
        end
        chk_state(req, to, 1'b0);
    endtask

    task automatic do_reset(input logic scl_level);
        @(negedge clk);
        rst = 1'b1;
        scl = scl_level;
        repeat (3) @(negedge clk);
        chk_state("R1 during reset", 100, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk_state("R1 after reset", 100, 1'b0);
    endtask

    task automatic t_reg_mode();
        ctl_en = 1'b1; pin_fn = 2'b00; reg_sel = 2'd1;
        settle_commit();
        chk_state("R5 commit", 100, 1'b1);
        do_tick();
        repeat (5) @(negedge clk);
        chk_state("R7 no tick", 101, 1'b1);
        walk("R6 up", 101, 106);
        do_tick();
        chk_state("R6 hold at target", 106, 1'b0);
    endtask

    task automatic t_retarget();
        reg_sel = 2'd2;
        settle_commit();
        chk_state("R9 commit down", 106, 1'b1);
        do_tick(); do_tick(); do_tick();
        chk_state("R6 down", 103, 1'b1);
        reg_sel = 2'd3;
        do_tick();
        do_tick();
        chk_state("R9 mid-walk retarget", 101, 1'b1);
        walk("R9 continue", 101, 103);
    endtask

    task automatic t_glitch();
        reg_sel = 2'd0;
        do_tick();
        reg_sel = 2'd3;
        do_tick();
        do_tick();
        do_tick();
        chk_state("R10 single-tick value not taken", 103, 1'b0);
    endtask

    task automatic t_disabled();
        ctl_en = 1'b0; reg_sel = 2'd0; pin_fn = 2'b11; oe = 1'b1; scl = 1'b0;
        repeat (4) @(negedge clk);
        repeat (4) do_tick();
        chk_state("R2 disabled ignores selection", 103, 1'b0);
    endtask

    task automatic t_single_pin();
        ctl_en = 1'b1; pin_fn = 2'b11; oe = 1'b1; scl = 1'b0; reg_sel = 2'd2;
        settle_commit();
        chk_state("R3 commit", 103, 1'b1);
        walk("R3 walk to word 1", 103, 106);
    endtask

    task automatic t_i2c_pins();
        do_reset(1'b0);
        ctl_en = 1'b1; pin_fn = 2'b01; scl = 1'b1; sda = 1'b1; reg_sel = 2'd1; oe = 1'b0;
        settle_commit();
        chk_state("R4 commit", 100, 1'b1);
        walk("R4 walk to word 3", 100, 103);
    endtask

    initial begin
        do_reset(1'b1);
        t_reg_mode();
        t_retarget();
        t_glitch();
        t_disabled();
        t_single_pin();
        t_i2c_pins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule